// File: doc/BRIEF.md
# Agree-Style Branch Direction Predictor

This block gives a taken or not-taken guess for a conditional branch. It does not store the direction of each branch. A table of 2-bit counters, called the agreement table, records whether the branch tends to follow a per-branch bias bit. A second table, called the bias table, holds that bias bit and a valid flag. The bias table is indexed by the branch address alone. The agreement table is indexed by the branch address XORed with a global history of resolved outcomes. The predict port is combinational. It takes an address and returns the direction together with the current history. The update port takes a resolved branch as its address, its actual outcome and the history that was in use when it was predicted.

A small controller with two states sequences the block. After reset it sits in `INIT`. There it writes one entry of each table per cycle: counters go to weakly agree and bias entries become invalid. Once the last index is written it takes the `INIT -> RUN` transition. It stays in `RUN` until the next reset; `RUN` has no transition out. Updates that arrive in `INIT` are dropped.

Top module: `agree_bpred`

## Requirements
- R1: After reset is released, `ready` stays low for exactly 2^max(PHT_IDX_W, DIR_IDX_W) rising clock edges (2048 by default), then goes high and stays high until the next reset.
- R2: The history register is zero after reset. Each accepted update (`upd_valid` high while `ready` is high) shifts it left by one and puts `upd_taken` into bit 0; the top bit drops out. Without an accepted update it holds. `pred_hist` always shows it.
- R3: A branch whose bias entry is still invalid is predicted taken. Its bias is read as 1 and a fresh counter reads as agree.
- R4: The agreement table index is `pc[PHT_IDX_W-1:0]` XOR the zero-extended history. The bias table index is `pc[DIR_IDX_W-1:0]`. For prediction the history is the internal register; for update it is `upd_hist`.
- R5: The first accepted update that reaches an invalid bias entry makes the entry valid and stores `upd_taken` as its bias. Later updates never change that bias.
- R6: On an accepted update, the counter at the update index counts up by one when the outcome equals the bias and down by one otherwise. It saturates at 0 and 3.
- R7: Counter values 2 and 3 mean agree, and the prediction is the bias. Values 0 and 1 mean disagree, and the prediction is the inverted bias.
- R8: Updates that arrive while `ready` is low change neither the history nor either table.
- R9: When `ready` first rises, every counter holds 2 (weakly agree) and every bias entry is invalid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| ready | output | 1 | High once table initialisation is complete |
| pred_pc | input | ADDR_W | Branch address to predict |
| pred_taken | output | 1 | Predicted direction, 1 = taken |
| pred_hist | output | HIST_W | Current global history, to be returned with the update |
| upd_valid | input | 1 | A resolved branch is presented this cycle |
| upd_pc | input | ADDR_W | Address of the resolved branch |
| upd_taken | input | 1 | Actual outcome, 1 = taken |
| upd_hist | input | HIST_W | History that was in use when the branch was predicted |

## Verification
A corrupted counter or bias entry shows up only as a wrong `pred_taken`, and only when the same address and history are presented again. The tests therefore return the history to a known value and predict right after each training step. Each of these predictions follows one registered update, so a wrong stored value appears on the next cycle. A saturation fault is caught by pushing a counter past its limit and reading it before it would wrap back. A fault that overwrites the bias on a later update is caught by the first disagreeing update, which flips the prediction too early. Faults in the history register are visible on `pred_hist` one cycle after the update that caused them.

// File: rtl/agree_bp_pkg.sv
package agree_bp_pkg;

    typedef enum logic {
        ST_INIT = 1'b0,
        ST_RUN  = 1'b1
    } bp_state_e;

    localparam logic [1:0] CTR_WEAK_AGREE = 2'd2;

    function automatic logic [1:0] ctr_step(input logic [1:0] c, input logic up);
        if (up) begin
            return (c == 2'd3) ? c : c + 2'd1;
        end
        return (c == 2'd0) ? c : c - 2'd1;
    endfunction

endpackage

// File: rtl/agree_bp_ctrl.sv
module agree_bp_ctrl
    import agree_bp_pkg::*;
#(
    parameter int SWEEP_W = 11
) (
    input  logic               clk,
    input  logic               rst_n,
    output logic               init_we,
    output logic [SWEEP_W-1:0] init_idx,
    output logic               ready
);

    bp_state_e          state_q, state_d;
    logic [SWEEP_W-1:0] sweep_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_INIT;
            sweep_q <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_INIT) begin
                sweep_q <= sweep_q + 1'b1;
            end
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_INIT: if (sweep_q == '1) state_d = ST_RUN;
            ST_RUN:  state_d = ST_RUN;
            default: state_d = ST_INIT;
        endcase
    end

    always_comb begin
        init_we  = 1'b0;
        ready    = 1'b0;
        init_idx = sweep_q;
        unique case (state_q)
            ST_INIT: init_we = 1'b1;
            ST_RUN:  ready   = 1'b1;
            default: init_we = 1'b0;
        endcase
    end

endmodule

// File: rtl/agree_bp_pht.sv
module agree_bp_pht
    import agree_bp_pkg::*;
#(
    parameter int IDX_W = 11
) (
    input  logic             clk,
    input  logic             init_we,
    input  logic [IDX_W-1:0] init_idx,
    input  logic [IDX_W-1:0] rd_idx_p,
    output logic [1:0]       rd_ctr_p,
    input  logic [IDX_W-1:0] rd_idx_u,
    output logic [1:0]       rd_ctr_u,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [1:0]       wr_ctr
);

    localparam int DEPTH = 1 << IDX_W;

    logic [1:0] ctr_mem [DEPTH];

    always_ff @(posedge clk) begin
        if (init_we) begin
            ctr_mem[init_idx] <= CTR_WEAK_AGREE;
        end else if (wr_en) begin
            ctr_mem[wr_idx] <= wr_ctr;
        end
    end

    assign rd_ctr_p = ctr_mem[rd_idx_p];
    assign rd_ctr_u = ctr_mem[rd_idx_u];

endmodule

// File: rtl/agree_bp_dir.sv
module agree_bp_dir #(
    parameter int IDX_W = 11
) (
    input  logic             clk,
    input  logic             init_we,
    input  logic [IDX_W-1:0] init_idx,
    input  logic [IDX_W-1:0] rd_idx_p,
    output logic             rd_vld_p,
    output logic             rd_bias_p,
    input  logic [IDX_W-1:0] rd_idx_u,
    output logic             rd_vld_u,
    output logic             rd_bias_u,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic             wr_bias
);

    localparam int DEPTH = 1 << IDX_W;

    logic vld_mem  [DEPTH];
    logic bias_mem [DEPTH];

    always_ff @(posedge clk) begin
        if (init_we) begin
            vld_mem[init_idx]  <= 1'b0;
            bias_mem[init_idx] <= 1'b0;
        end else if (wr_en) begin
            vld_mem[wr_idx]  <= 1'b1;
            bias_mem[wr_idx] <= wr_bias;
        end
    end

    assign rd_vld_p  = vld_mem[rd_idx_p];
    assign rd_bias_p = bias_mem[rd_idx_p];
    assign rd_vld_u  = vld_mem[rd_idx_u];
    assign rd_bias_u = bias_mem[rd_idx_u];

endmodule

// File: rtl/agree_bpred.sv
module agree_bpred
    import agree_bp_pkg::*;
#(
    parameter int ADDR_W    = 11,
    parameter int PHT_IDX_W = 11,
    parameter int DIR_IDX_W = 11,
    parameter int HIST_W    = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic              ready,
    input  logic [ADDR_W-1:0] pred_pc,
    output logic              pred_taken,
    output logic [HIST_W-1:0] pred_hist,
    input  logic              upd_valid,
    input  logic [ADDR_W-1:0] upd_pc,
    input  logic              upd_taken,
    input  logic [HIST_W-1:0] upd_hist
);

    localparam int SWEEP_W = (PHT_IDX_W > DIR_IDX_W) ? PHT_IDX_W : DIR_IDX_W;

    logic                 init_we;
    logic [SWEEP_W-1:0]   init_idx;
    logic [HIST_W-1:0]    ghr_q;
    logic                 upd_fire;

    logic [PHT_IDX_W-1:0] pht_idx_p, pht_idx_u;
    logic [DIR_IDX_W-1:0] dir_idx_p, dir_idx_u;
    logic [1:0]           ctr_p, ctr_u, ctr_new;
    logic                 vld_p, bias_p, vld_u, bias_u;
    logic                 eff_bias_p, eff_bias_u;

    agree_bp_ctrl #(.SWEEP_W(SWEEP_W)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .init_we  (init_we),
        .init_idx (init_idx),
        .ready    (ready)
    );

    assign upd_fire = upd_valid & ready;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ghr_q <= '0;
        end else if (upd_fire) begin
            ghr_q <= {ghr_q[HIST_W-2:0], upd_taken};
        end
    end

    assign pred_hist = ghr_q;

    assign dir_idx_p = pred_pc[DIR_IDX_W-1:0];
    assign dir_idx_u = upd_pc[DIR_IDX_W-1:0];
    assign pht_idx_p = pred_pc[PHT_IDX_W-1:0] ^ PHT_IDX_W'(ghr_q);
    assign pht_idx_u = upd_pc[PHT_IDX_W-1:0] ^ PHT_IDX_W'(upd_hist);

    agree_bp_pht #(.IDX_W(PHT_IDX_W)) u_pht (
        .clk      (clk),
        .init_we  (init_we),
        .init_idx (init_idx[PHT_IDX_W-1:0]),
        .rd_idx_p (pht_idx_p),
        .rd_ctr_p (ctr_p),
        .rd_idx_u (pht_idx_u),
        .rd_ctr_u (ctr_u),
        .wr_en    (upd_fire),
        .wr_idx   (pht_idx_u),
        .wr_ctr   (ctr_new)
    );

    agree_bp_dir #(.IDX_W(DIR_IDX_W)) u_dir (
        .clk       (clk),
        .init_we   (init_we),
        .init_idx  (init_idx[DIR_IDX_W-1:0]),
        .rd_idx_p  (dir_idx_p),
        .rd_vld_p  (vld_p),
        .rd_bias_p (bias_p),
        .rd_idx_u  (dir_idx_u),
        .rd_vld_u  (vld_u),
        .rd_bias_u (bias_u),
        .wr_en     (upd_fire & ~vld_u),
        .wr_idx    (dir_idx_u),
        .wr_bias   (upd_taken)
    );

    // Unseen branch: bias reads as taken on predict, as the outcome on update.
    assign eff_bias_p = vld_p ? bias_p : 1'b1;
    assign eff_bias_u = vld_u ? bias_u : upd_taken;
    assign ctr_new    = ctr_step(ctr_u, upd_taken == eff_bias_u);
    assign pred_taken = ctr_p[1] ? eff_bias_p : ~eff_bias_p;

endmodule

// File: rtl/agree_bpred_chk.sv
module agree_bpred_chk #(
    parameter int HIST_W = 11
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ready,
    input logic              upd_valid,
    input logic              upd_taken,
    input logic [HIST_W-1:0] pred_hist
);

    AST_READY_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
        ready |=> ready); // R1

    AST_INIT_HIST_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !ready |-> (pred_hist == '0)); // R8

    AST_HIST_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && upd_valid) |=> (pred_hist == {$past(pred_hist[HIST_W-2:0]), $past(upd_taken)})); // R2

    AST_HIST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && !upd_valid) |=> $stable(pred_hist)); // R2

endmodule

bind agree_bpred agree_bpred_chk #(.HIST_W(HIST_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ready     (ready),
    .upd_valid (upd_valid),
    .upd_taken (upd_taken),
    .pred_hist (pred_hist)
);

// File: tb/agree_bpred_tb.sv
module agree_bpred_tb;

    localparam int AW = 11;
    localparam int HW = 11;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ready;
    logic [AW-1:0] pred_pc = '0;
    logic          pred_taken;
    logic [HW-1:0] pred_hist;
    logic          upd_valid = 1'b0;
    logic [AW-1:0] upd_pc = '0;
    logic          upd_taken = 1'b0;
    logic [HW-1:0] upd_hist = '0;

    int n_tests = 0;
    int n_fail  = 0;

    always #5 clk = ~clk;

    agree_bpred u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .ready      (ready),
        .pred_pc    (pred_pc),
        .pred_taken (pred_taken),
        .pred_hist  (pred_hist),
        .upd_valid  (upd_valid),
        .upd_pc     (upd_pc),
        .upd_taken  (upd_taken),
        .upd_hist   (upd_hist)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic upd(input int pc, input bit tk, input int h);
        @(negedge clk);
        upd_valid = 1'b1;
        upd_pc    = AW'(pc);
        upd_taken = tk;
        upd_hist  = HW'(h);
        @(negedge clk);
        upd_valid = 1'b0;
    endtask

    // Return history to zero through not-taken updates on a reserved region.
    task automatic flush();
        for (int k = 0; k < HW; k++) upd(12'h700 + k, 1'b0, 0);
    endtask

    task automatic pred_chk(input string req, input int pc, input bit exp);
        pred_pc = AW'(pc);
        #1;
        chk(req, int'(pred_taken), int'(exp));
    endtask

    task automatic t_init();
        int cnt = 0;
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1 ready low in reset", int'(ready), 0);
        rst_n = 1'b1;
        for (int i = 0; i < 5000; i++) begin
            if (i < 4) begin
                upd_valid = 1'b1; upd_pc = AW'(12'h020); upd_taken = 1'b0; upd_hist = '0;
            end else begin
                upd_valid = 1'b0;
            end
            @(posedge clk);
            cnt++;
            @(negedge clk);
            if (ready) break;
        end
        upd_valid = 1'b0;
        chk("R1 init length", cnt, 2048);
        chk("R8 history untouched by init-time update", int'(pred_hist), 0);
        pred_chk("R8 table untouched by init-time update", 12'h020, 1'b1);
        @(negedge clk);
        chk("R1 ready stays high", int'(ready), 1);
    endtask

    task automatic t_unseen();
        pred_chk("R3 unseen predicts taken", 12'h0AA, 1'b1);
        pred_chk("R9 counter weak agree, bias invalid", 12'h155, 1'b1);
        pred_chk("R3 unseen predicts taken top", 12'h3FF, 1'b1);
    endtask

    task automatic t_bias_low();
        upd(12'h100, 1'b0, 0); flush();
        pred_chk("R5 bias captured not-taken", 12'h100, 1'b0);
        upd(12'h100, 1'b1, 0); flush();
        pred_chk("R5 bias kept after disagree", 12'h100, 1'b0);
        upd(12'h100, 1'b1, 0); flush();
        pred_chk("R7 disagree inverts bias", 12'h100, 1'b1);
        upd(12'h100, 1'b1, 0); upd(12'h100, 1'b1, 0); flush();
        pred_chk("R6 saturate at 0", 12'h100, 1'b1);
        upd(12'h100, 1'b0, 0); flush();
        pred_chk("R6 count up 0->1", 12'h100, 1'b1);
        upd(12'h100, 1'b0, 0); flush();
        pred_chk("R6 count up 1->2 agree", 12'h100, 1'b0);
    endtask

    task automatic t_bias_high();
        upd(12'h200, 1'b1, 0); upd(12'h200, 1'b1, 0); upd(12'h200, 1'b1, 0); flush();
        pred_chk("R6 saturate at 3", 12'h200, 1'b1);
        upd(12'h200, 1'b0, 0); flush();
        pred_chk("R6 count down 3->2", 12'h200, 1'b1);
        upd(12'h200, 1'b0, 0); flush();
        pred_chk("R7 disagree inverts taken bias", 12'h200, 1'b0);
    endtask

    task automatic t_index();
        upd(12'h040, 1'b0, 0);
        upd(12'h040, 1'b1, 3); upd(12'h040, 1'b1, 3); flush();
        pred_chk("R4 index with zero history", 12'h040, 1'b0);
        upd(12'h600, 1'b1, 0); upd(12'h601, 1'b1, 0);
        chk("R2 history after two taken", int'(pred_hist), 3);
        pred_chk("R4 index xor history", 12'h040, 1'b1);
    endtask

    task automatic t_hist();
        flush();
        chk("R2 history flushed", int'(pred_hist), 0);
        upd(12'h300, 1'b1, 0); upd(12'h301, 1'b0, 0);
        upd(12'h302, 1'b1, 0); upd(12'h303, 1'b1, 0);
        chk("R2 history pattern", int'(pred_hist), 11);
        for (int i = 0; i < HW; i++) upd(12'h310 + i, 1'b1, 0);
        chk("R2 history all ones", int'(pred_hist), 12'h7FF);
        upd(12'h320, 1'b0, 0);
        chk("R2 history drops top bit", int'(pred_hist), 12'h7FE);
        repeat (3) @(negedge clk);
        chk("R2 history holds when idle", int'(pred_hist), 12'h7FE);
    endtask

    initial begin
        #(200000 * 10);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        t_init();
        t_unseen();
        t_bias_low();
        t_bias_high();
        t_index();
        t_hist();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule